// File: doc/BRIEF.md
# Integer Arithmetic Unit with Status Flags

This block is the add/subtract datapath of an integer execution stage. It takes a destination operand, a source operand, an operation code and an operand size of 8, 16 or 32 bits. It produces the result at once, without a clock. The six status flags are carry, parity, auxiliary carry, zero, sign and overflow. They are held in a register that is written on the next rising clock edge.

The operations are add, subtract, increment, decrement and negate. Increment, decrement and negate work on the destination operand alone. All flags are judged at the selected width, except parity, which always looks at the low byte. For a narrow size, the result bits above the selected width carry the destination's old contents. When the flag-write enable is low, the flags are left as they are. This lets the caller model data moves that must not touch the flags.

The adder is built from byte lanes. The size input chooses which lane supplies the carry out, the overflow and the sign. A reserved operation code leaves both the result and the flags alone.

Top module: `int_flag_alu`

## Requirements
- R1: Operation code 0 is add. The result is dst + src at the selected width, and the carry flag is the carry out of that width's top bit. Size code 0 selects 8 bits, code 1 selects 16 bits, and codes 2 and 3 select 32 bits.
- R2: Operation code 1 is subtract. The result is dst - src at the selected width, and the carry flag is set exactly when src is greater than dst as unsigned numbers. This borrow is the inverted carry out of dst + ~src + 1.
- R3: The overflow flag is set only when the two addends have the same sign and the result has the opposite sign. A subtrahend counts with its sign inverted. For example, 8-bit 0x80 + 0x80 gives 0x00 with carry, zero, parity and overflow set.
- R4: Operation code 2 (increment, dst + 1) and operation code 3 (decrement, dst - 1) update overflow, sign, zero, auxiliary carry and parity. They leave the carry flag at its previous value.
- R5: For add and increment, the auxiliary carry flag is the carry out of bit 3. For subtract, decrement and negate, it is the borrow into bit 4.
- R6: The parity flag is 1 when bits 7:0 of the result hold an even number of ones, whatever the operand size.
- R7: The sign flag copies the top bit of the result at the selected width. The zero flag is set when every result bit at that width is 0. The two are therefore never set together.
- R8: Operation code 4 is negate, giving 0 - dst. Its carry flag is 1 for any nonzero operand and 0 for zero. Negating the most negative value returns that same value with overflow set.
- R9: At size 8 or 16, result bits above the selected width equal the same bits of dst.
- R10: When flag_we_i is low, the flags register keeps all six bits across the clock edge.
- R11: Operation codes 5 to 7 are reserved. The result equals dst, and the flags are not written even when flag_we_i is high.
- R12: The flags are at flags_o bit 0 carry, bit 1 parity, bit 2 auxiliary carry, bit 3 zero, bit 4 sign and bit 5 overflow. A synchronous active-high reset clears all of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flags register |
| rst | input | 1 | Synchronous active-high reset of the flags |
| op_i | input | 3 | Operation code (0 add, 1 sub, 2 inc, 3 dec, 4 neg, 5-7 reserved) |
| size_i | input | 2 | Operand size (0: 8 bits, 1: 16 bits, 2/3: 32 bits) |
| dst_i | input | 32 | Destination operand, also the source of the pass-through upper bits |
| src_i | input | 32 | Source operand for add and subtract |
| flag_we_i | input | 1 | Flag-write enable |
| res_o | output | 32 | Combinational result |
| flags_o | output | 6 | Registered flags {overflow, sign, zero, aux carry, parity, carry} |

## Verification
At 8 bits, add, subtract, increment, decrement and negate are swept over every destination value against sixteen spread source values. This covers carry, borrow, half-carry and signed-overflow cases from simple arithmetic.

At 16 and 32 bits, eight edge values are crossed with each other under every operation:
- zero, one, the two values on either side of the sign boundary, all-ones, a low nibble of ones, and a mixed pattern;
- the upper destination bits are set to junk, so the upper-lane pass-through is tested as well;
- these crosses separate the carry at the selected width from the carry out of the full 32 bits.

Directed cases cover the fixed flag patterns of overflow, half carry, low-byte-only parity, negating zero and the most negative value, a held enable, reserved codes and reset.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_SUB = 3'd1;
  localparam logic [2:0] OP_INC = 3'd2;
  localparam logic [2:0] OP_DEC = 3'd3;
  localparam logic [2:0] OP_NEG = 3'd4;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zer;
    logic aux;
    logic par;
    logic cry;
  } alu_flags_t;

  localparam int FLAG_W = $bits(alu_flags_t);

endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] b_o,
  output logic              cin_o,
  output logic              sub_like_o,
  output logic              keep_cry_o,
  output logic              valid_o
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  always_comb begin
    a_o        = dst_i;
    b_o        = '0;
    cin_o      = 1'b0;
    sub_like_o = 1'b0;
    keep_cry_o = 1'b0;
    valid_o    = 1'b1;
    unique case (op_i)
      OP_ADD: b_o = src_i;
      OP_SUB: begin
        b_o        = ~src_i;
        cin_o      = 1'b1;
        sub_like_o = 1'b1;
      end
      OP_INC: begin
        cin_o      = 1'b1;
        keep_cry_o = 1'b1;
      end
      OP_DEC: begin
        b_o        = ~ONE;
        cin_o      = 1'b1;
        sub_like_o = 1'b1;
        keep_cry_o = 1'b1;
      end
      OP_NEG: begin
        a_o        = '0;
        b_o        = ~dst_i;
        cin_o      = 1'b1;
        sub_like_o = 1'b1;
      end
      default: valid_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_lane_adder.sv
module alu_lane_adder #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] sum_o,
  output logic [DATA_W/LANE_W-1:0] lane_cout_o,
  output logic [DATA_W/LANE_W-1:0] lane_cmsb_o,
  output logic              c4_o
);

  localparam int NLANES = DATA_W / LANE_W;

  logic [NLANES:0] chain;
  assign chain[0] = cin_i;

  for (genvar k = 0; k < NLANES; k++) begin : g_lane
    logic [LANE_W-2:0] lo_sum;
    logic              mid_c;
    logic              hi_sum;
    logic              hi_c;
    localparam int BASE = k * LANE_W;

    assign {mid_c, lo_sum} = {1'b0, a_i[BASE +: LANE_W-1]}
                           + {1'b0, b_i[BASE +: LANE_W-1]}
                           + {{(LANE_W-1){1'b0}}, chain[k]};
    assign {hi_c, hi_sum}  = {1'b0, a_i[BASE+LANE_W-1]}
                           + {1'b0, b_i[BASE+LANE_W-1]}
                           + {1'b0, mid_c};

    assign sum_o[BASE +: LANE_W] = {hi_sum, lo_sum};
    assign lane_cmsb_o[k]        = mid_c;
    assign lane_cout_o[k]        = hi_c;
    assign chain[k+1]            = hi_c;
  end

  assign c4_o = a_i[4] ^ b_i[4] ^ sum_o[4];

endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0]        sum_i,
  input  logic [DATA_W/LANE_W-1:0] lane_cout_i,
  input  logic [DATA_W/LANE_W-1:0] lane_cmsb_i,
  input  logic [DATA_W/LANE_W-1:0] lane_en_i,
  input  logic [DATA_W/LANE_W-1:0] lane_last_i,
  input  logic                     c4_i,
  input  logic                     sub_like_i,
  input  logic                     keep_cry_i,
  input  logic                     old_cry_i,
  output alu_flags_t               flags_o
);

  localparam int NLANES = DATA_W / LANE_W;

  logic cout_sel;
  logic cmsb_sel;
  logic msb_sel;
  logic any_one;

  always_comb begin
    cout_sel = 1'b0;
    cmsb_sel = 1'b0;
    msb_sel  = 1'b0;
    any_one  = 1'b0;
    for (int k = 0; k < NLANES; k++) begin
      if (lane_last_i[k]) begin
        cout_sel = lane_cout_i[k];
        cmsb_sel = lane_cmsb_i[k];
        msb_sel  = sum_i[k*LANE_W + LANE_W - 1];
      end
      if (lane_en_i[k] && (sum_i[k*LANE_W +: LANE_W] != '0)) begin
        any_one = 1'b1;
      end
    end
  end

  always_comb begin
    flags_o.ovf = cmsb_sel ^ cout_sel;
    flags_o.sgn = msb_sel;
    flags_o.zer = ~any_one;
    flags_o.aux = c4_i ^ sub_like_i;
    flags_o.par = ~^sum_i[7:0];
    flags_o.cry = keep_cry_i ? old_cry_i : (cout_sel ^ sub_like_i);
  end

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_flag_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we_i,
  input  alu_flags_t next_i,
  output alu_flags_t flags_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
    end else if (we_i) begin
      flags_q <= next_i;
    end
  end

endmodule

// File: rtl/int_flag_alu.sv
module int_flag_alu
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic              flag_we_i,
  output logic [DATA_W-1:0] res_o,
  output logic [5:0]        flags_o
);

  localparam int NLANES = DATA_W / LANE_W;

  logic [DATA_W-1:0] op_a;
  logic [DATA_W-1:0] op_b;
  logic              cin;
  logic              sub_like;
  logic              keep_cry;
  logic              op_valid;
  logic [DATA_W-1:0] sum;
  logic [NLANES-1:0] lane_cout;
  logic [NLANES-1:0] lane_cmsb;
  logic [NLANES-1:0] lane_en;
  logic [NLANES-1:0] lane_last;
  logic              c4;
  alu_flags_t        next_flags;
  alu_flags_t        cur_flags;

  alu_operand_prep #(.DATA_W(DATA_W)) prep_i (
    .op_i       (op_i),
    .dst_i      (dst_i),
    .src_i      (src_i),
    .a_o        (op_a),
    .b_o        (op_b),
    .cin_o      (cin),
    .sub_like_o (sub_like),
    .keep_cry_o (keep_cry),
    .valid_o    (op_valid)
  );

  alu_lane_adder #(.DATA_W(DATA_W), .LANE_W(LANE_W)) add_i (
    .a_i         (op_a),
    .b_i         (op_b),
    .cin_i       (cin),
    .sum_o       (sum),
    .lane_cout_o (lane_cout),
    .lane_cmsb_o (lane_cmsb),
    .c4_o        (c4)
  );

  // Size code n enables the lowest 2**n lanes, clamped to the full width.
  always_comb begin
    for (int k = 0; k < NLANES; k++) begin
      lane_en[k] = (k < (32'sd1 <<< size_i));
    end
  end
  assign lane_last = lane_en & ~(lane_en >> 1);

  alu_flag_gen #(.DATA_W(DATA_W), .LANE_W(LANE_W)) flg_i (
    .sum_i       (sum),
    .lane_cout_i (lane_cout),
    .lane_cmsb_i (lane_cmsb),
    .lane_en_i   (lane_en),
    .lane_last_i (lane_last),
    .c4_i        (c4),
    .sub_like_i  (sub_like),
    .keep_cry_i  (keep_cry),
    .old_cry_i   (cur_flags.cry),
    .flags_o     (next_flags)
  );

  alu_flag_reg freg_i (
    .clk     (clk),
    .rst     (rst),
    .we_i    (flag_we_i & op_valid),
    .next_i  (next_flags),
    .flags_q (cur_flags)
  );

  for (genvar k = 0; k < NLANES; k++) begin : g_res
    assign res_o[k*LANE_W +: LANE_W] = (op_valid && lane_en[k])
                                       ? sum[k*LANE_W +: LANE_W]
                                       : dst_i[k*LANE_W +: LANE_W];
  end

  assign flags_o = cur_flags;

endmodule

// File: rtl/int_flag_alu_chk.sv
module int_flag_alu_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        op_i,
  input logic [1:0]        size_i,
  input logic [DATA_W-1:0] dst_i,
  input logic              flag_we_i,
  input logic [DATA_W-1:0] res_o,
  input logic [5:0]        flags_o
);

  p_reset_clear_r12: assert property (@(posedge clk)
    rst |=> (flags_o == 6'd0));

  p_hold_flags_r10: assert property (@(posedge clk) disable iff (rst)
    !flag_we_i |=> $stable(flags_o));

  p_keep_carry_r4: assert property (@(posedge clk) disable iff (rst)
    (flag_we_i && (op_i == 3'd2 || op_i == 3'd3)) |=> (flags_o[0] == $past(flags_o[0])));

  p_neg_carry_r8: assert property (@(posedge clk) disable iff (rst)
    (flag_we_i && op_i == 3'd4 && size_i[1]) |=> (flags_o[0] == ($past(dst_i) != '0)));

  p_zero_sign_r7: assert property (@(posedge clk) disable iff (rst)
    flags_o[3] |-> !flags_o[4]);

  p_upper_pass_r9: assert property (@(posedge clk) disable iff (rst)
    (size_i == 2'd0) |-> (res_o[DATA_W-1:8] == dst_i[DATA_W-1:8]));

  p_reserved_res_r11: assert property (@(posedge clk) disable iff (rst)
    (op_i > 3'd4) |-> (res_o == dst_i));

  p_reserved_flags_r11: assert property (@(posedge clk) disable iff (rst)
    (op_i > 3'd4) |=> $stable(flags_o));

endmodule

bind int_flag_alu int_flag_alu_chk #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .op_i      (op_i),
  .size_i    (size_i),
  .dst_i     (dst_i),
  .flag_we_i (flag_we_i),
  .res_o     (res_o),
  .flags_o   (flags_o)
);

// File: tb/int_flag_alu_tb_top.sv
module int_flag_alu_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op_i = '0;
  logic [1:0]  size_i = '0;
  logic [31:0] dst_i = '0;
  logic [31:0] src_i = '0;
  logic        flag_we_i = 1'b0;
  logic [31:0] res_o;
  logic [5:0]  flags_o;

  int checks = 0;
  int failures = 0;
  logic [5:0] exp_f = '0;

  always #5 clk = ~clk;

  int_flag_alu dut_i (
    .clk(clk), .rst(rst), .op_i(op_i), .size_i(size_i), .dst_i(dst_i),
    .src_i(src_i), .flag_we_i(flag_we_i), .res_o(res_o), .flags_o(flags_o)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Arithmetic model: flags {ovf,sgn,zer,aux,par,cry}.
  function automatic void model(input logic [2:0] op, input logic [1:0] sz,
                                input logic [31:0] d, input logic [31:0] s,
                                input logic [5:0] oldf,
                                output logic [31:0] res, output logic [5:0] nf,
                                output bit upd);
    int w;
    logic [63:0] m, a, b, x, y, r;
    bit subm, cf, af, of, sx, sy, sr;
    w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    m = (64'd1 << w) - 64'd1;
    a = {32'd0, d} & m;
    b = {32'd0, s} & m;
    upd = 1'b1;
    case (op)
      3'd0: begin x = a; y = b; subm = 0; end
      3'd1: begin x = a; y = b; subm = 1; end
      3'd2: begin x = a; y = 64'd1; subm = 0; end
      3'd3: begin x = a; y = 64'd1; subm = 1; end
      3'd4: begin x = 64'd0; y = a; subm = 1; end
      default: begin
        res = d; nf = oldf; upd = 1'b0;
        return;
      end
    endcase
    sx = x[w-1];
    sy = y[w-1];
    if (!subm) begin
      r  = (x + y) & m;
      cf = (x + y) > m;
      af = ((x & 64'hF) + (y & 64'hF)) > 64'hF;
      of = (sx == sy) && (r[w-1] != sx);
    end else begin
      r  = (x - y) & m;
      cf = x < y;
      af = (x & 64'hF) < (y & 64'hF);
      of = (sx != sy) && (r[w-1] != sx);
    end
    sr = r[w-1];
    if (op == 3'd2 || op == 3'd3) cf = oldf[0];
    res = (d & ~m[31:0]) | r[31:0];
    nf  = {of, sr, (r == 64'd0), af, ~^r[7:0], cf};
  endfunction

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2, 3'd3: return "R4";
      3'd4: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic run(input logic [2:0] op, input logic [1:0] sz,
                     input logic [31:0] d, input logic [31:0] s,
                     input logic we, input string tag);
    logic [31:0] er;
    logic [5:0]  ef;
    bit          u;
    @(negedge clk);
    op_i = op; size_i = sz; dst_i = d; src_i = s; flag_we_i = we;
    #1;
    model(op, sz, d, s, exp_f, er, ef, u);
    chk(tag, "result", res_o, er);
    if (u && we) exp_f = ef;
    @(posedge clk);
    #1;
    chk(tag, "flags", {26'd0, flags_o}, {26'd0, exp_f});
  endtask

  function automatic logic [31:0] edge_val(input int k, input logic [1:0] sz);
    logic [31:0] m;
    m = (sz == 2'd1) ? 32'h0000FFFF : 32'hFFFFFFFF;
    case (k)
      0: return 32'd0;
      1: return 32'd1;
      2: return m >> 1;
      3: return (m >> 1) + 32'd1;
      4: return m;
      5: return 32'h0000000F;
      6: return m & 32'hA5C35A3C;
      default: return m - 32'd1;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R12", "reset flags", {26'd0, flags_o}, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // R3: 8-bit 0x80 + 0x80 -> 0x00, ovf/zer/par/cry set
    run(3'd0, 2'd0, 32'h00000080, 32'h00000080, 1'b1, "R3");
    chk("R3", "fixed flags", {26'd0, flags_o}, 32'h2B);
    // R7: 16-bit 0x7FFF + 1 -> 0x8000, ovf/sgn/aux/par
    run(3'd0, 2'd1, 32'h00007FFF, 32'h00000001, 1'b1, "R7");
    chk("R7", "fixed flags", {26'd0, flags_o}, 32'h36);
    // R6: parity only on low byte: 0x103 -> par set
    run(3'd0, 2'd2, 32'h00000100, 32'h00000003, 1'b1, "R6");
    chk("R6", "fixed flags", {26'd0, flags_o}, 32'h02);
    // R5: 0x0F + 1 at 8 bits -> aux only
    run(3'd0, 2'd0, 32'h0000000F, 32'h00000001, 1'b1, "R5");
    chk("R5", "fixed flags", {26'd0, flags_o}, 32'h04);
    // R8: negate most negative and zero
    run(3'd4, 2'd2, 32'h80000000, 32'h0, 1'b1, "R8");
    chk("R8", "fixed flags", {26'd0, flags_o}, 32'h33);
    run(3'd4, 2'd2, 32'h00000000, 32'h0, 1'b1, "R8");
    chk("R8", "fixed flags", {26'd0, flags_o}, 32'h0A);
    // R4: set carry, then increment keeps it
    run(3'd0, 2'd0, 32'h000000FF, 32'h00000002, 1'b1, "R4");
    run(3'd2, 2'd0, 32'hAABBCCFF, 32'h0, 1'b1, "R4");
    chk("R4", "carry kept", {31'd0, flags_o[0]}, 32'd1);
    chk("R9", "upper pass", res_o, 32'hAABBCC00);
    // R10: disabled write leaves flags
    run(3'd1, 2'd0, 32'h00000000, 32'h00000001, 1'b0, "R10");
    chk("R10", "held flags", {26'd0, flags_o}, {26'd0, exp_f});
    // R11: reserved codes
    for (int c = 5; c < 8; c++) begin
      run(3'(c), 2'd2, 32'h12345678, 32'h9ABCDEF0, 1'b1, "R11");
    end

    // 8-bit sweep over all ops
    for (int op = 0; op < 5; op++) begin
      for (int d = 0; d < 256; d++) begin
        for (int s = 0; s < 256; s += 17) begin
          run(3'(op), 2'd0, 32'(d) | 32'h5A5A5A00, 32'(s) | 32'hC3C3C300,
              1'b1, tag_of(3'(op)));
        end
      end
    end

    // 16/32-bit edge crosses with junk upper bits
    for (int sz = 1; sz < 4; sz++) begin
      for (int op = 0; op < 5; op++) begin
        for (int i = 0; i < 8; i++) begin
          for (int j = 0; j < 8; j++) begin
            run(3'(op), 2'(sz),
                edge_val(i, 2'(sz)) | ((sz == 1) ? 32'hDEAD0000 : 32'h0),
                edge_val(j, 2'(sz)), 1'b1, tag_of(3'(op)));
          end
        end
      end
    end

    // R12: reset in mid-run clears flags
    run(3'd1, 2'd0, 32'h00000000, 32'h00000081, 1'b1, "R12");
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R12", "reset clears", {26'd0, flags_o}, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule